// File: doc/BRIEF.md
# I2C Slave Streaming Register Port

This block is an I2C fast-mode slave with a 7-bit address. A host reaches a byte-wide transmit FIFO through a 256-entry register space. Two registers near the top of that space give the number of pending FIFO bytes. The topmost register drains the FIFO one byte per read. The slave keeps a register pointer. Each read advances the pointer, but the pointer stops at the topmost register and stays there. Because the pointer resets to that register, a plain read with no register address streams the FIFO.

Write transactions have two uses, and the number of data bytes decides which. A single data byte only moves the register pointer. This is the first half of a random read, which is then finished with a repeated START and a read. Two or more data bytes form a message. The message is forwarded byte by byte on a receive stream, and a strobe marks its final byte. The slave never stretches the clock and ignores general calls.

Top module: `i2c_stream_port`

## Requirements
- R1: The slave acknowledges an address byte only when its upper 7 bits equal `cfg_addr[7:1]`. Bit 0 of the address byte is the direction (1 = read). On a mismatch SDA stays released until the next START.
- R2: After reset the pointer is 0xFF, SDA is released, and a read with no register address returns the head of the FIFO.
- R3: A read at pointer 0xFF returns the FIFO head and pulses `tx_pop` once. When `tx_count` is zero it returns 0xFF and does not pop.
- R4: A read at 0xFD returns `tx_count[15:8]` and captures `tx_count[7:0]`. A read at 0xFE returns the byte captured at the most recent 0xFD read.
- R5: A read at any pointer from 0x00 to 0xFC returns 0x00.
- R6: The pointer advances by one after each byte read, except at 0xFF, where it stays.
- R7: A write transaction with exactly one data byte loads that byte into the pointer and produces no `rx_valid`.
- R8: A write transaction with two or more data bytes puts every data byte on `rx_data` in order, each with one `rx_valid` pulse. The final byte also carries `rx_last`. The pointer is left unchanged.
- R9: A one-byte write followed by a repeated START and a read begins reading at the register just written.
- R10: After the master answers a read byte with NACK, no further byte is fetched and `tx_pop` stays low until a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | 8 | Slave address in bits 7:1; bit 0 is unused |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_count | input | 16 | Number of bytes in the transmit FIFO |
| tx_pop | output | 1 | Removes the FIFO head (one-cycle pulse) |
| rx_data | output | 8 | Received message byte |
| rx_valid | output | 1 | `rx_data` is valid this cycle |
| rx_last | output | 1 | This byte ends a message |

## Verification
One bus event can end a message and start a new transaction in the same clock cycle. A repeated START both flushes the held final byte of a two-byte message, with `rx_last`, and begins decoding the next address. A later repeated START then loads the pointer from a one-byte write. The bench sends exactly this chain: a message, a repeated START, a pointer write, a repeated START, and a read. It then checks three things: the order of the received bytes, the `rx_last` flag on the second byte only, and that the byte read comes from the newly set register.

// File: rtl/i2c_sp_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the I2C streaming register port.
// Assumes a 16-bit pending count, split over two byte registers.
package i2c_sp_pkg;
    parameter int CNT_W = 16;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] REG_CNT_HI    = 8'hFD;
    localparam logic [BYTE_W-1:0] REG_CNT_LO    = 8'hFE;
    localparam logic [BYTE_W-1:0] REG_STREAM    = 8'hFF;
    localparam logic [BYTE_W-1:0] EMPTY_BYTE    = 8'hFF;
    localparam logic [BYTE_W-1:0] RESERVED_BYTE = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WDATA,
        ST_RDATA,
        ST_RACK
    } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
// Synchronizes SCL and SDA into clk, then reports SCL edges and
// START/STOP conditions, which are SDA edges seen while SCL is high.
// Assumes clk is at least ~8x faster than SCL. Lines reset to idle-high.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;
    logic            scl_now, scl_prev, sda_prev;

    // Synchronizer chains plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    // Decode edges and bus conditions from the synchronized levels.
    always_comb begin
        scl_now  = scl_q[STAGES-1];
        scl_prev = scl_q[STAGES];
        sda_s    = sda_q[STAGES-1];
        sda_prev = sda_q[STAGES];
        scl_rise = scl_now & ~scl_prev;
        scl_fall = ~scl_now & scl_prev;
        start_ev = scl_now & scl_prev & sda_prev & ~sda_s;
        stop_ev  = scl_now & scl_prev & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/stream_regfile.sv
`timescale 1ns/1ps
// Register pointer and read-data selection for the port.
// A 'take' strobe marks a byte handed to the bus. It advances the
// pointer (held at the top register), pops the FIFO at the stream
// register, and captures the low count byte at the high-count register.
// Assumes 'take' and 'load' come from one controller, one per byte.
module stream_regfile
    import i2c_sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic [CNT_W-1:0]  tx_count,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              tx_pop
);
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] cnt_lo;
    logic              fifo_has;

    assign fifo_has = (tx_count != '0);
    assign tx_pop   = take && (ptr == REG_STREAM) && fifo_has;

    // Pointer update: a load wins; otherwise step unless at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= REG_STREAM;
        end else if (load) begin
            ptr <= load_val;
        end else if (take && ptr != REG_STREAM) begin
            ptr <= ptr + 8'd1;
        end
    end

    // Capture the low count byte when the high byte goes out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo <= '0;
        end else if (take && ptr == REG_CNT_HI) begin
            cnt_lo <= tx_count[BYTE_W-1:0];
        end
    end

    // Read-data selection by pointer.
    always_comb begin
        case (ptr)
            REG_CNT_HI: rd_byte = tx_count[CNT_W-1:CNT_W-BYTE_W];
            REG_CNT_LO: rd_byte = cnt_lo;
            REG_STREAM: rd_byte = fifo_has ? tx_data : EMPTY_BYTE;
            default:    rd_byte = RESERVED_BYTE;
        endcase
    end

    a_r6_ptr_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !load && ptr == REG_STREAM) |=> (ptr == REG_STREAM));
    a_r6_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !load && ptr != REG_STREAM) |=> (ptr == $past(ptr) + 8'd1));
    a_r3_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (tx_count != '0));
    a_r7_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(load_val)));
endmodule

// File: rtl/i2c_stream_port.sv
`timescale 1ns/1ps
// I2C slave bridging a 256-entry register space to a transmit FIFO
// and a receive message stream. Holds one written byte back so that a
// one-byte write can become a pointer load and longer writes a message.
// Assumes no clock stretching and an oversampling system clock.
module i2c_stream_port
    import i2c_sp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cfg_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic [CNT_W-1:0]  tx_count,
    output logic              tx_pop,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_last
);
    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    bus_state_t        state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg, hold_byte, ptr_val, rd_byte, wbyte;
    logic              is_read, ack_half, take, ptr_load;
    logic [1:0]        wr_cnt;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    stream_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .take(take), .load(ptr_load),
        .load_val(ptr_val), .tx_data(tx_data), .tx_count(tx_count),
        .rd_byte(rd_byte), .tx_pop(tx_pop)
    );

    // Completed write byte: seven shifted bits plus the current one.
    assign wbyte = {shreg[BYTE_W-2:0], sda_s};

    // Protocol sequencer: address, acknowledge, data in/out, write close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;   bit_cnt <= '0;  shreg <= '0;
            hold_byte <= '0;    ptr_val <= '0;  is_read <= 1'b0;
            ack_half <= 1'b0;   wr_cnt <= '0;   sda_oe <= 1'b0;
            take <= 1'b0;       ptr_load <= 1'b0;
            rx_data <= '0;      rx_valid <= 1'b0; rx_last <= 1'b0;
        end else begin
            take     <= 1'b0;
            ptr_load <= 1'b0;
            rx_valid <= 1'b0;
            rx_last  <= 1'b0;
            if (start_ev || stop_ev) begin
                if (wr_cnt == 2'd1) begin
                    ptr_load <= 1'b1;
                    ptr_val  <= hold_byte;
                end else if (wr_cnt == 2'd2) begin
                    rx_valid <= 1'b1;
                    rx_last  <= 1'b1;
                    rx_data  <= hold_byte;
                end
                wr_cnt   <= '0;
                sda_oe   <= 1'b0;
                bit_cnt  <= '0;
                ack_half <= 1'b0;
                state    <= start_ev ? ST_ADDR : ST_IDLE;
            end else begin
                case (state)
                    ST_ADDR: if (scl_rise) begin
                        shreg   <= wbyte;
                        bit_cnt <= bit_cnt + 4'd1;
                        if (bit_cnt == 4'd7) begin
                            if (shreg[6:0] == cfg_addr[BYTE_W-1:1]) begin
                                is_read <= sda_s;
                                state   <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!ack_half) begin
                            sda_oe   <= 1'b1;
                            ack_half <= 1'b1;
                        end else begin
                            ack_half <= 1'b0;
                            bit_cnt  <= '0;
                            if (is_read) begin
                                shreg  <= rd_byte;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                take   <= 1'b1;
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: if (scl_rise) begin
                        shreg   <= wbyte;
                        bit_cnt <= bit_cnt + 4'd1;
                        if (bit_cnt == 4'd7) begin
                            hold_byte <= wbyte;
                            if (wr_cnt == 2'd0) begin
                                wr_cnt <= 2'd1;
                            end else begin
                                rx_valid <= 1'b1;
                                rx_data  <= hold_byte;
                                wr_cnt   <= 2'd2;
                            end
                            state <= ST_ACK;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise && sda_s) begin
                            state <= ST_IDLE;
                        end else if (scl_fall) begin
                            shreg   <= rd_byte;
                            sda_oe  <= ~rd_byte[BYTE_W-1];
                            take    <= 1'b1;
                            bit_cnt <= '0;
                            state   <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_last |-> rx_valid);
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
    a_r7_load_not_message: assert property (@(posedge clk) disable iff (!rst_n)
        !(ptr_load && rx_valid));
    a_r10_no_fetch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE) |-> !take);
endmodule

// File: tb/sim_i2c_stream_port.sv
`timescale 1ns/1ps
// Directed bench: bit-banged I2C master, FIFO model, receive capture.
module sim_i2c_stream_port;
    localparam int Q = 10;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, tx_pop, rx_valid, rx_last;
    logic [7:0] rx_data, tx_data;
    logic [15:0] tx_count;
    logic [7:0] cfg_addr = 8'h84;
    logic sda_i;

    logic [7:0] fq [0:31];
    int head = 0, tail = 0;
    logic ov_en = 1'b0;
    logic [15:0] ov_val = '0;
    logic [7:0] rx_buf [0:31];
    logic       rx_lst [0:31];
    int rx_n = 0;
    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    assign sda_i    = sda_m & ~sda_oe;
    assign tx_count = ov_en ? ov_val : 16'(tail - head);
    assign tx_data  = fq[head[4:0]];

    i2c_stream_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .scl_i(scl_m),
        .sda_i(sda_i), .sda_oe(sda_oe), .tx_data(tx_data),
        .tx_count(tx_count), .tx_pop(tx_pop), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_last(rx_last)
    );

    always @(negedge clk) begin
        if (tx_pop) head = head + 1;
        if (rx_valid) begin
            rx_buf[rx_n[4:0]] = rx_data;
            rx_lst[rx_n[4:0]] = rx_last;
            rx_n = rx_n + 1;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_q; repeat (Q) @(negedge clk); endtask
    task automatic m_start; sda_m = 1; wait_q; scl_m = 1; wait_q; sda_m = 0; wait_q; scl_m = 0; wait_q; endtask
    task automatic m_stop; sda_m = 0; wait_q; scl_m = 1; wait_q; sda_m = 1; wait_q; endtask
    task automatic m_bit(input logic b); sda_m = b; wait_q; scl_m = 1; wait_q; wait_q; scl_m = 0; wait_q; endtask
    task automatic m_rbit(output logic b); sda_m = 1; wait_q; scl_m = 1; wait_q; b = sda_i; wait_q; scl_m = 0; wait_q; endtask

    task automatic wr(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        m_rbit(a);
        ack = ~a;
    endtask

    task automatic rd(output logic [7:0] b, input logic last);
        logic x;
        for (int i = 7; i >= 0; i--) begin m_rbit(x); b[i] = x; end
        m_bit(last);
    endtask

    task automatic push(input logic [7:0] b); fq[tail[4:0]] = b; tail = tail + 1; endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        m_start; wr(8'h84, a); wr(p, a); m_stop;
    endtask

    task automatic t_reset;
        logic a; logic [7:0] d;
        check("R2 sda released", {15'd0, sda_oe}, 16'd0);
        check("R2 no pop", {15'd0, tx_pop}, 16'd0);
        check("R2 no rx", {15'd0, rx_valid}, 16'd0);
        push(8'hA1); push(8'hA2); push(8'hA3);
        m_start; wr(8'h85, a);
        check("R1 ack on match", {15'd0, a}, 16'd1);
        rd(d, 1'b0); check("R2 first stream byte", {8'd0, d}, 16'h00A1);
        rd(d, 1'b1); check("R6 stays at stream reg", {8'd0, d}, 16'h00A2);
        m_stop;
        check("R10 pops after nack", 16'(head), 16'd2);
        m_start; wr(8'h85, a);
        rd(d, 1'b0); check("R3 stream byte", {8'd0, d}, 16'h00A3);
        rd(d, 1'b1); check("R3 empty reads FF", {8'd0, d}, 16'h00FF);
        m_stop;
        check("R3 no pop when empty", 16'(head), 16'd3);
    endtask

    task automatic t_addr_mismatch;
        logic a; int n0;
        n0 = rx_n;
        m_start; wr(8'h86, a); check("R1 nack wrong addr", {15'd0, a}, 16'd0); m_stop;
        m_start; wr(8'h04, a); check("R1 nack msb differs", {15'd0, a}, 16'd0); m_stop;
        check("R1 no rx after mismatch", 16'(rx_n - n0), 16'd0);
    endtask

    task automatic t_ptr_set;
        logic a; logic [7:0] d; int n0;
        n0 = rx_n;
        set_ptr(8'h10);
        check("R7 single byte gives no rx", 16'(rx_n - n0), 16'd0);
        m_start; wr(8'h85, a);
        rd(d, 1'b0); check("R5 reserved 0x10", {8'd0, d}, 16'h0000);
        rd(d, 1'b1); check("R5 reserved 0x11", {8'd0, d}, 16'h0000);
        m_stop;
    endtask

    task automatic t_walk;
        logic a; logic [7:0] d;
        push(8'hB1);
        set_ptr(8'hFC);
        m_start; wr(8'h85, a);
        rd(d, 1'b0); check("R5 reserved 0xFC", {8'd0, d}, 16'h0000);
        rd(d, 1'b0); check("R4 count high", {8'd0, d}, 16'h0000);
        rd(d, 1'b0); check("R4 count low", {8'd0, d}, 16'h0001);
        rd(d, 1'b0); check("R6 reached stream", {8'd0, d}, 16'h00B1);
        rd(d, 1'b1); check("R6 sticks at FF", {8'd0, d}, 16'h00FF);
        m_stop;
        check("R3 single pop", 16'(head), 16'd4);
    endtask

    task automatic t_count_latch;
        logic a; logic [7:0] d;
        ov_en = 1'b1; ov_val = 16'h1234;
        m_start; wr(8'h84, a); wr(8'hFD, a); m_start; wr(8'h85, a);
        rd(d, 1'b1); m_stop;
        check("R9 random read high", {8'd0, d}, 16'h0012);
        ov_val = 16'h5678;
        m_start; wr(8'h84, a); wr(8'hFE, a); m_start; wr(8'h85, a);
        rd(d, 1'b1); m_stop;
        check("R4 low byte latched", {8'd0, d}, 16'h0034);
    endtask

    task automatic t_msg;
        logic a; logic [7:0] d; int n0;
        set_ptr(8'hFD);
        n0 = rx_n;
        m_start; wr(8'h84, a); wr(8'hFF, a); wr(8'h66, a); wr(8'h77, a); m_stop;
        check("R8 three bytes", 16'(rx_n - n0), 16'd3);
        check("R8 byte0", {7'd0, rx_lst[n0[4:0]], rx_buf[n0[4:0]]}, 16'h00FF);
        check("R8 byte1", {7'd0, rx_lst[n0[4:0]+5'd1], rx_buf[n0[4:0]+5'd1]}, 16'h0066);
        check("R8 byte2 last", {7'd0, rx_lst[n0[4:0]+5'd2], rx_buf[n0[4:0]+5'd2]}, 16'h0177);
        m_start; wr(8'h85, a); rd(d, 1'b1); m_stop;
        check("R8 pointer untouched", {8'd0, d}, 16'h0056);
    endtask

    task automatic t_sr_flush;
        logic a; logic [7:0] d; int n0;
        n0 = rx_n;
        m_start; wr(8'h84, a); wr(8'h11, a); wr(8'h22, a);
        m_start; wr(8'h84, a); wr(8'hFE, a);
        m_start; wr(8'h85, a); rd(d, 1'b1); m_stop;
        check("R8 flush on restart count", 16'(rx_n - n0), 16'd2);
        check("R8 first not last", {7'd0, rx_lst[n0[4:0]], rx_buf[n0[4:0]]}, 16'h0011);
        check("R8 second last", {7'd0, rx_lst[n0[4:0]+5'd1], rx_buf[n0[4:0]+5'd1]}, 16'h0122);
        check("R9 read at new pointer", {8'd0, d}, 16'h0078);
        ov_en = 1'b0;
    endtask

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_addr_mismatch;
        t_ptr_set;
        t_walk;
        t_count_latch;
        t_msg;
        t_sr_flush;
        repeat (20) @(negedge clk);
        finish_up;
    end
endmodule